// File: doc/BRIEF.md
# Asynchronous Bus Cycle Controller

This block runs one external read or write on an asynchronous, strobe-based memory bus on behalf of a processor core. The core raises a request while the controller is idle. The request carries an address, a supervisor/user flag, a program/data flag, the transfer direction and a word/byte flag. The controller then steps through four bus states of one clock each. The function code goes out first, the address follows one clock later, and the address strobe rises in the third state. The cycle completes on the edge that ends the fourth state when a transfer acknowledge or a bus error is present on that edge.

When neither response is present on the decision edge, the controller inserts whole wait clocks and holds the strobe until a response arrives. An acknowledge latches the read data. A bus error completes the cycle and raises a trap request for the core. A word access to an odd address is detected before the strobe would rise. The strobe then never asserts, although the function code and address have already been on the pins. In every case the core sees a one-clock completion pulse with the status flags, and the core's next step starts from that pulse.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the controller is idle: `core_ready`=1, and `bus_as`, `bus_fc_en`, `bus_addr_en`, `bus_wdata_en`, `core_done`, `core_bus_err` and `core_addr_err` are all 0, with `bus_rw_n`=1.
- R2: In the first clock after a request is accepted (state S0), `bus_fc_en`=1 and `bus_fc` = {supervisor, program, not program}, so user program=2, user data=1, supervisor program=6 and supervisor data=5. In that clock `bus_addr_en` and `bus_as` are still 0. The code stays stable until the cycle ends.
- R3: From the second clock (S1) until the last strobe clock, `bus_addr_en`=1 and `bus_addr` equals the requested address.
- R4: `bus_as` rises in the third clock (S2), stays high through S3 and any wait clocks, and is low in the completion clock.
- R5: With a response on the first decision edge (the edge that ends S3), `core_done` is a one-clock pulse in the fifth clock after acceptance. The bus part of the cycle therefore lasts 4 clocks.
- R6: Each decision edge without `bus_ack` or `bus_err` adds exactly one wait clock with `bus_as` held high, so N such edges put `core_done` in clock 5+N.
- R7: `bus_ack` seen on any edge before the end of S3 has no effect: the strobe still runs through S3, and `core_done` is not raised early.
- R8: For a read, the `bus_rdata` present on the decision edge with `bus_ack` appears on `core_rdata` from the completion clock on. Writes and failed cycles leave `core_rdata` unchanged.
- R9: `bus_err` on a decision edge completes the cycle with `core_bus_err`=1 together with `core_done`. It takes priority over a simultaneous `bus_ack` and latches no data.
- R10: A word access (`core_word`=1) to an odd address completes in the third clock with `core_done`=1 and `core_addr_err`=1, and `bus_as` is never asserted. A byte access to an odd address runs as a normal cycle.
- R11: A write drives `bus_rw_n`=0 from S1 through the last strobe clock, and drives `bus_wdata_en`=1 with `bus_wdata` equal to the request data while the strobe is high. A read keeps `bus_rw_n`=1.
- R12: A request is accepted only while `core_ready`=1, which holds in the idle state alone. A request raised during a cycle is dropped, and no new bus cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Transfer request, taken when idle |
| core_addr | input | ADDR_W | Byte address of the transfer |
| core_supervisor | input | 1 | 1 = supervisor access |
| core_program | input | 1 | 1 = program space, 0 = data space |
| core_write | input | 1 | 1 = write, 0 = read |
| core_word | input | 1 | 1 = word access, 0 = byte access |
| core_wdata | input | DATA_W | Write data |
| core_ready | output | 1 | Controller idle, request may be raised |
| core_done | output | 1 | One-clock completion pulse |
| core_rdata | output | DATA_W | Last read data latched |
| core_bus_err | output | 1 | Cycle ended by bus error (trap request) |
| core_addr_err | output | 1 | Cycle ended by odd word address (trap request) |
| bus_fc | output | 3 | Function code |
| bus_fc_en | output | 1 | Function code driven |
| bus_addr | output | ADDR_W | Address lines |
| bus_addr_en | output | 1 | Address driven |
| bus_as | output | 1 | Address strobe, active high |
| bus_rw_n | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | DATA_W | Write data lines |
| bus_wdata_en | output | 1 | Write data driven |
| bus_rdata | input | DATA_W | Read data lines |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_err | input | 1 | Bus error response |

## Verification
The controller is tried with zero-wait reads and with cycles stretched by one, two and three wait clocks. These show whether the completion clock moves by exactly one per missing response and whether the strobe stays high across the waits. An acknowledge held only through S0 to S2 separates a controller that samples on the decision edge alone from one that reacts early. A bus error on its own, and a bus error together with an acknowledge, show error priority and that the read data register is untouched. Odd word addresses (read and write) against an odd byte address separate the alignment trap from ordinary cycles, and a request raised mid-cycle shows that requests are taken only when idle.

// File: rtl/bcc_pkg.sv
// Package: shared state type, request attributes and function-code encoding
// for the asynchronous bus cycle controller.
package bcc_pkg;

    // Bus phases; one clock each except PH_WAIT, which repeats.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_S0   = 3'd1,
        PH_S1   = 3'd2,
        PH_S2   = 3'd3,
        PH_S3   = 3'd4,
        PH_WAIT = 3'd5,
        PH_END  = 3'd6
    } phase_e;

    // Attributes of the accepted request.
    typedef struct packed {
        logic sup;
        logic prog;
        logic write;
        logic word;
    } req_attr_t;

    localparam int FC_W = 3;

    // Function code: {supervisor, program, data}.
    function automatic logic [FC_W-1:0] fc_encode(input logic sup, input logic prog);
        return {sup, prog, ~prog};
    endfunction

endpackage

// File: rtl/bcc_sequencer.sv
// Module: bcc_sequencer
// Steps the bus phases for one transfer. It assumes the request registers
// hold the address from S1 on, so alignment is judged there. Responses count
// only on the edge that ends S3 or a wait clock.
module bcc_sequencer
    import bcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_fire,
    input  logic   misaligned,
    input  logic   ack,
    input  logic   err,
    output phase_e phase,
    output logic   end_berr,
    output logic   end_aerr,
    output logic   data_latch
);

    phase_e phase_nx;
    logic   decide;

    assign decide     = (phase == PH_S3) || (phase == PH_WAIT);
    assign data_latch = decide && ack && !err;

    // Next-phase selection from the current phase and sampled responses.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (req_fire) phase_nx = PH_S0;
            PH_S0:   phase_nx = PH_S1;
            PH_S1:   phase_nx = misaligned ? PH_END : PH_S2;
            PH_S2:   phase_nx = PH_S3;
            PH_S3, PH_WAIT: phase_nx = (err || ack) ? PH_END : PH_WAIT;
            PH_END:  phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and completion status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            end_berr <= 1'b0;
            end_aerr <= 1'b0;
        end else begin
            phase <= phase_nx;
            if (phase == PH_S1 && misaligned) begin
                end_aerr <= 1'b1;
            end
            if (decide && err) begin
                end_berr <= 1'b1;
            end
            if (phase == PH_END) begin
                end_berr <= 1'b0;
                end_aerr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bcc_request_regs.sv
// Module: bcc_request_regs
// Holds the accepted request, the address output register (loaded while in
// S0 so it is valid from S1) and the read data latch. It assumes
// `capture` only pulses while the controller is idle.
module bcc_request_regs
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              addr_load,
    input  logic              data_latch,
    input  req_attr_t         attr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output req_attr_t         attr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [ADDR_W-1:0] addr_pend;

    // Request capture when the controller accepts a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q    <= '0;
            addr_pend <= '0;
            wdata_q   <= '0;
        end else if (capture) begin
            attr_q    <= attr_in;
            addr_pend <= addr_in;
            wdata_q   <= wdata_in;
        end
    end

    // Address output register, loaded at the S0 to S1 edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_load) begin
            addr_q <= addr_pend;
        end
    end

    // Read data latch on an acknowledged read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (data_latch && !attr_q.write) begin
            rdata_q <= rdata_in;
        end
    end

endmodule

// File: rtl/bcc_pin_decode.sv
// Module: bcc_pin_decode
// Combinational decode of the bus and core-side pins from the phase. It
// assumes the request registers are stable for the whole cycle.
module bcc_pin_decode
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  phase_e            phase,
    input  req_attr_t         attr,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              end_berr,
    input  logic              end_aerr,
    output logic [FC_W-1:0]   fc,
    output logic              fc_en,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_en,
    output logic              as_o,
    output logic              rw_n,
    output logic [DATA_W-1:0] wdata,
    output logic              wdata_en,
    output logic              ready,
    output logic              done,
    output logic              berr_o,
    output logic              aerr_o
);

    logic strobe_ph;

    // Phase windows for each pin group.
    always_comb begin
        strobe_ph = (phase == PH_S2) || (phase == PH_S3) || (phase == PH_WAIT);
        fc_en     = (phase == PH_S0) || (phase == PH_S1) || strobe_ph;
        addr_en   = (phase == PH_S1) || strobe_ph;
        as_o      = strobe_ph;
        rw_n      = !(attr.write && addr_en);
        wdata_en  = attr.write && strobe_ph;
        fc        = fc_en ? fc_encode(attr.sup, attr.prog) : '0;
        addr      = addr_en ? addr_q : '0;
        wdata     = wdata_en ? wdata_q : '0;
        ready     = (phase == PH_IDLE);
        done      = (phase == PH_END);
        berr_o    = done && end_berr;
        aerr_o    = done && end_aerr;
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
// Module: bus_cycle_ctrl
// Runs one asynchronous bus read or write per request: function code in S0,
// address in S1, strobe from S2, decision on the edge ending S3 or a wait
// clock. It assumes the core holds its request fields during the accept
// clock and waits for core_done before its next step.
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_supervisor,
    input  logic              core_program,
    input  logic              core_write,
    input  logic              core_word,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic              core_done,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_bus_err,
    output logic              core_addr_err,
    output logic [2:0]        bus_fc,
    output logic              bus_fc_en,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_en,
    output logic              bus_as,
    output logic              bus_rw_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_en,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    phase_e            phase;
    req_attr_t         attr_in, attr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              req_fire, misaligned, end_berr, end_aerr, data_latch;

    assign attr_in    = '{sup: core_supervisor, prog: core_program,
                          write: core_write, word: core_word};
    assign req_fire   = core_req && (phase == PH_IDLE);
    assign misaligned = attr_q.word && addr_q[0];

    bcc_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .misaligned (misaligned),
        .ack        (bus_ack),
        .err        (bus_err),
        .phase      (phase),
        .end_berr   (end_berr),
        .end_aerr   (end_aerr),
        .data_latch (data_latch)
    );

    bcc_request_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (req_fire),
        .addr_load  (phase == PH_S0),
        .data_latch (data_latch),
        .attr_in    (attr_in),
        .addr_in    (core_addr),
        .wdata_in   (core_wdata),
        .rdata_in   (bus_rdata),
        .attr_q     (attr_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .rdata_q    (core_rdata)
    );

    bcc_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase    (phase),
        .attr     (attr_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .end_berr (end_berr),
        .end_aerr (end_aerr),
        .fc       (bus_fc),
        .fc_en    (bus_fc_en),
        .addr     (bus_addr),
        .addr_en  (bus_addr_en),
        .as_o     (bus_as),
        .rw_n     (bus_rw_n),
        .wdata    (bus_wdata),
        .wdata_en (bus_wdata_en),
        .ready    (core_ready),
        .done     (core_done),
        .berr_o   (core_bus_err),
        .aerr_o   (core_addr_err)
    );

endmodule

// File: rtl/bus_cycle_ctrl_checker.sv
// Module: bus_cycle_ctrl_checker
// Protocol properties on the ports of bus_cycle_ctrl; attached by bind.
module bus_cycle_ctrl_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_ready,
    input logic              core_done,
    input logic              core_bus_err,
    input logic              core_addr_err,
    input logic [2:0]        bus_fc,
    input logic              bus_fc_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_addr_en,
    input logic              bus_as,
    input logic              bus_rw_n,
    input logic              bus_wdata_en
);

    assert_fc_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fc_en && $past(bus_fc_en)) |-> $stable(bus_fc));

    assert_fc_before_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_addr_en) |-> $past(bus_fc_en));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_en && $past(bus_addr_en)) |-> $stable(bus_addr));

    assert_as_after_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_as) |-> $past(bus_addr_en));

    assert_done_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !core_addr_err) |-> ($past(bus_as) && !bus_as));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);

    assert_flags_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_bus_err || core_addr_err) |-> (core_done && $onehot0({core_bus_err, core_addr_err})));

    assert_no_strobe_on_aerr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_addr_err |-> (!bus_as && !$past(bus_as)));

    assert_wdata_in_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wdata_en |-> (bus_as && !bus_rw_n));

    assert_ready_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> (!bus_fc_en && !bus_addr_en && !bus_as));

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_ready    (core_ready),
    .core_done     (core_done),
    .core_bus_err  (core_bus_err),
    .core_addr_err (core_addr_err),
    .bus_fc        (bus_fc),
    .bus_fc_en     (bus_fc_en),
    .bus_addr      (bus_addr),
    .bus_addr_en   (bus_addr_en),
    .bus_as        (bus_as),
    .bus_rw_n      (bus_rw_n),
    .bus_wdata_en  (bus_wdata_en)
);

// File: tb/bus_cycle_ctrl_bench.sv
// Directed bench for bus_cycle_ctrl: one task per scenario.
module bus_cycle_ctrl_bench;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic          core_supervisor = 1'b0, core_program = 1'b0;
    logic          core_write = 1'b0, core_word = 1'b0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_ready, core_done, core_bus_err, core_addr_err;
    logic [DW-1:0] core_rdata;
    logic [2:0]    bus_fc;
    logic          bus_fc_en, bus_addr_en, bus_as, bus_rw_n, bus_wdata_en;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0, bus_err = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] exp_rdata = '0;

    always #4 clk = ~clk;

    bus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_bus_cycle_ctrl (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_fc(input bit sup, input bit prog);
        if (!sup) return prog ? 3'd2 : 3'd1;
        return prog ? 3'd6 : 3'd5;
    endfunction

    // One full transfer. resp: 0 = ack, 1 = berr, 2 = berr with ack.
    task automatic xfer(input logic [AW-1:0] addr, input bit sup, input bit prog,
                        input bit wr, input bit word, input logic [DW-1:0] wd,
                        input int waits, input int resp, input bit early_ack,
                        input bit poke, input logic [DW-1:0] rd);
        bit odd_word;
        odd_word = word && addr[0];
        @(negedge clk);
        core_req = 1; core_addr = addr; core_supervisor = sup; core_program = prog;
        core_write = wr; core_word = word; core_wdata = wd; bus_rdata = rd;
        @(negedge clk); // S0
        core_req = 0;
        chk(bus_fc_en == 1 && bus_fc == exp_fc(sup, prog), "R2", "fc in S0", bus_fc, exp_fc(sup, prog));
        chk(bus_addr_en == 0 && bus_as == 0, "R2", "addr/as idle in S0", {bus_addr_en, bus_as}, 0);
        chk(core_ready == 0, "R12", "busy in S0", core_ready, 0);
        if (early_ack) bus_ack = 1;
        if (poke) begin core_req = 1; core_addr = addr ^ 24'h000100; end
        @(negedge clk); // S1
        chk(bus_addr_en == 1 && bus_addr == addr, "R3", "addr in S1", bus_addr, addr);
        chk(bus_as == 0, "R4", "no strobe in S1", bus_as, 0);
        chk(bus_rw_n == !wr, "R11", "rw_n in S1", bus_rw_n, !wr);
        @(negedge clk); // S2 or address-error end
        if (odd_word) begin
            chk(core_done && core_addr_err && !core_bus_err, "R10", "addr error end",
                {core_done, core_addr_err, core_bus_err}, 3'b110);
            chk(bus_as == 0, "R10", "no strobe on addr error", bus_as, 0);
            chk(core_rdata == exp_rdata, "R8", "rdata kept on addr error", core_rdata, exp_rdata);
        end else begin
            chk(bus_as == 1 && bus_fc == exp_fc(sup, prog), "R4", "strobe in S2", bus_as, 1);
            if (wr) chk(bus_wdata_en && bus_wdata == wd, "R11", "write data in S2", bus_wdata, wd);
            else chk(bus_wdata_en == 0 && bus_rw_n == 1, "R11", "read keeps rw high", bus_rw_n, 1);
            @(negedge clk); // S3
            if (early_ack) bus_ack = 0;
            chk(bus_as == 1 && core_done == 0, early_ack ? "R7" : "R4", "strobe in S3, no done",
                {bus_as, core_done}, 2'b10);
            for (int i = 0; i <= waits; i++) begin
                if (i > 0) begin
                    @(negedge clk); // wait clock i
                    chk(bus_as == 1 && core_done == 0 && bus_addr == addr, "R6", "held in wait",
                        {bus_as, core_done}, 2'b10);
                end
                if (i == waits) begin
                    bus_ack = (resp != 1);
                    bus_err = (resp != 0);
                    bus_rdata = rd;
                end
            end
            @(negedge clk); // completion
            bus_ack = 0; bus_err = 0; bus_rdata = ~rd;
            chk(core_done == 1 && bus_as == 0, waits == 0 ? "R5" : "R6", "done clock",
                {core_done, bus_as}, 2'b10);
            if (resp == 0) begin
                chk(core_bus_err == 0 && core_addr_err == 0, "R5", "clean completion",
                    {core_bus_err, core_addr_err}, 0);
                if (!wr) exp_rdata = rd;
                chk(core_rdata == exp_rdata, "R8", "read data", core_rdata, exp_rdata);
            end else begin
                chk(core_bus_err == 1 && core_addr_err == 0, "R9", "bus error flag",
                    {core_bus_err, core_addr_err}, 2'b10);
                chk(core_rdata == exp_rdata, "R9", "no latch on bus error", core_rdata, exp_rdata);
            end
        end
        core_req = 0;
        @(negedge clk); // idle
        chk(core_ready == 1 && core_done == 0, "R12", "idle after done", {core_ready, core_done}, 2'b10);
        @(negedge clk);
        chk(bus_fc_en == 0 && bus_as == 0 && core_ready == 1, poke ? "R12" : "R1",
            "no further cycle", {bus_fc_en, bus_as}, 0);
        if (!wr && resp == 0 && !odd_word)
            chk(core_rdata == exp_rdata, "R8", "rdata held", core_rdata, exp_rdata);
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(core_ready && !bus_as && !bus_fc_en && !bus_addr_en && !bus_wdata_en && bus_rw_n,
            "R1", "reset pins", {core_ready, bus_as, bus_fc_en, bus_addr_en, bus_rw_n}, 5'b10001);
        chk(!core_done && !core_bus_err && !core_addr_err, "R1", "reset status",
            {core_done, core_bus_err, core_addr_err}, 0);
    endtask

    bit finished = 0;

    initial begin
        t_reset();
        xfer(24'h001000, 0, 1, 0, 1, 16'h0000, 0, 0, 0, 0, 16'h4E71); // R5 user program read
        xfer(24'h020468, 1, 0, 0, 1, 16'h0000, 2, 0, 0, 0, 16'hA5C3); // R6 supervisor data read
        xfer(24'h00FFF0, 0, 0, 1, 1, 16'h1234, 1, 0, 0, 0, 16'h0BAD); // R11 user data write
        xfer(24'h000400, 1, 1, 0, 1, 16'h0000, 0, 0, 1, 1, 16'h600E); // R7 and R12
        xfer(24'h300000, 1, 0, 0, 1, 16'h0000, 3, 1, 0, 0, 16'hDEAD); // R9 bus error
        xfer(24'h300002, 0, 0, 0, 1, 16'h0000, 0, 2, 0, 0, 16'hBEEF); // R9 priority
        xfer(24'h001001, 0, 0, 0, 1, 16'h0000, 0, 0, 0, 0, 16'h7777); // R10 odd word read
        xfer(24'h002003, 1, 0, 1, 1, 16'h5555, 0, 0, 0, 0, 16'h0000); // R10 odd word write
        xfer(24'h002003, 0, 0, 0, 0, 16'h0000, 1, 0, 0, 0, 16'h00C4); // R10 odd byte read
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule